// File: doc/BRIEF.md
# Two-Lane Interleaved Phase Accumulator

This block is a square-wave frequency synthesizer that reaches twice the output rate a single phase accumulator could give from the same clock. It holds two accumulators that always move together. When a step value is loaded, the first lane starts at zero and the second lane starts one step ahead. From then on, each lane adds twice the step on every clock edge. Between them, the two lanes visit every point a single accumulator would visit if it were clocked twice as fast.

The top bit of each lane is the synthesized waveform. A phase-multiplexed output shows the first lane's top bit while the clock is low and the second lane's top bit while the clock is high. Both top bits are also given as a plain registered 2-bit bus, and both accumulator values are brought out. A new step value reaches the lanes only through the load strobe. This lets the source of the step value change or bounce without disturbing the waveform.

Top module: `twin_phase_nco`

## Requirements
- R1: During a synchronous active-low reset, both accumulators are cleared. The stored stride is also cleared, so with no load after reset both accumulators stay at 0.
- R2: On the clock edge where `load_i` is 1, lane A (`acc_a_o`) becomes 0 and lane B (`acc_b_o`) becomes `step_i`. Both lanes change on that same edge.
- R3: On every later edge with `load_i` at 0, each lane adds the stride modulo 2^16. The stride is the loaded step shifted left one bit, with the step's bit 15 dropped and bit 0 filled with 0.
- R4: After a load of step N, `acc_b_o - acc_a_o` (mod 2^16) equals N on every cycle until the next load or reset.
- R5: A change of `step_i` while `load_i` is 0 has no effect on either accumulator.
- R6: `msb_pair_o` bit 0 is bit 15 of lane A, and bit 1 is bit 15 of lane B.
- R7: `wave_o` equals lane A's bit 15 while `clk` is low and lane B's bit 15 while `clk` is high.
- R8: After a load of step N, the sequence A, B, A, B of top bits taken cycle by cycle equals the top bits of k·N (mod 2^16) for k = 0, 1, 2, 3 and onward.
- R9: A load issued while the lanes are running restarts both lanes from 0 and the new N on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its level also selects the lane shown on `wave_o` |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 16 | Step value N |
| load_i | input | 1 | Strobe that captures `step_i` and restarts both lanes |
| acc_a_o | output | 16 | Lane A accumulator |
| acc_b_o | output | 16 | Lane B accumulator |
| msb_pair_o | output | 2 | {lane B bit 15, lane A bit 15} |
| wave_o | output | 1 | Phase-multiplexed waveform |

## Verification
Every accumulator result is due one edge after the stimulus that causes it. A load or reset seen at edge k shows at edge k+1, and each following edge adds one stride. The bench drives inputs 2 ns after a rising edge and samples at that same point, so it reads the values of the edge just passed. The expectations count j edges since the load: lane A is at 2jN and lane B at (2j+1)N. `wave_o` is checked twice per cycle, once 2 ns after the rising edge (clock high, lane B) and once 2 ns after the falling edge (clock low, lane A). Both samples read the same registered values.

// File: rtl/twin_nco_pkg.sv
// Package: shared sizing for the interleaved phase accumulator.
// Assumes exactly two lanes; lane index 0 is the low-phase lane.
package twin_nco_pkg;
    localparam int unsigned LANES    = 2;
    localparam int unsigned LANE_LO  = 0;
    localparam int unsigned LANE_HI  = 1;
    localparam int unsigned LANE_IDX = $clog2(LANES);

    typedef logic [LANE_IDX-1:0] lane_t;
endpackage

// File: rtl/nco_stride_reg.sv
// Module: holds the per-edge stride (step times lane count, truncated).
// Assumes load_i is synchronous; the stride only changes on a load or reset.
module nco_stride_reg #(
    parameter int unsigned W     = 16,
    parameter int unsigned LANES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] step_i,
    output logic [W-1:0] stride_o
);
    localparam int unsigned PW = W + $clog2(LANES) + 1;

    logic [PW-1:0] product;

    // Purpose: scale the step by the lane count at full width.
    always_comb begin
        product = PW'(step_i) * PW'(LANES);
    end

    // Purpose: capture the truncated stride on a load, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stride_o <= '0;
        end else if (load_i) begin
            stride_o <= product[W-1:0];
        end
    end
endmodule

// File: rtl/nco_lane_acc.sv
// Module: one phase accumulator lane, loaded with a start value or advanced by the stride.
// Assumes start_i is valid in the cycle load_i is high; arithmetic wraps modulo 2^W.
module nco_lane_acc #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] stride_i,
    output logic [W-1:0] acc_o
);
    logic [W-1:0] acc_next;

    // Purpose: wrapping sum of the lane and its stride, carry discarded.
    always_comb begin
        acc_next = acc_o + stride_i;
    end

    // Purpose: reset, restart from the start value, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (load_i) begin
            acc_o <= start_i;
        end else begin
            acc_o <= acc_next;
        end
    end
endmodule

// File: rtl/nco_phase_mux.sv
// Module: shows the low-phase lane bit while the clock is low and the other lane's bit while it is high.
// Assumes a clock with roughly even duty cycle; the selection is purely combinational.
module nco_phase_mux (
    input  logic phase_i,
    input  logic bit_lo_i,
    input  logic bit_hi_i,
    output logic wave_o
);
    // Purpose: choose the lane bit by clock level.
    always_comb begin
        wave_o = phase_i ? bit_hi_i : bit_lo_i;
    end
endmodule

// File: rtl/twin_phase_nco.sv
// Module: two-lane interleaved phase accumulator (top).
// Lane g starts at g*N on a load; all lanes advance by LANES*N per edge.
// Assumes a synchronous active-low reset and a single clock.
module twin_phase_nco
    import twin_nco_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] step_i,
    input  logic         load_i,
    output logic [W-1:0] acc_a_o,
    output logic [W-1:0] acc_b_o,
    output logic [1:0]   msb_pair_o,
    output logic         wave_o
);
    localparam int unsigned PW = W + LANE_IDX + 1;

    logic [W-1:0] stride;
    logic [W-1:0] lane_acc   [LANES];
    logic [W-1:0] lane_start [LANES];
    logic [LANES-1:0] lane_msb;

    nco_stride_reg #(.W(W), .LANES(LANES)) u_stride (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .step_i   (step_i),
        .stride_o (stride)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PW-1:0] offs;

        // Purpose: start value of this lane is its index times the step.
        always_comb begin
            offs          = PW'(step_i) * PW'(g);
            lane_start[g] = offs[W-1:0];
        end

        nco_lane_acc #(.W(W)) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load_i),
            .start_i  (lane_start[g]),
            .stride_i (stride),
            .acc_o    (lane_acc[g])
        );

        assign lane_msb[g] = lane_acc[g][W-1];
    end

    nco_phase_mux u_mux (
        .phase_i  (clk),
        .bit_lo_i (lane_msb[LANE_LO]),
        .bit_hi_i (lane_msb[LANE_HI]),
        .wave_o   (wave_o)
    );

    assign acc_a_o    = lane_acc[LANE_LO];
    assign acc_b_o    = lane_acc[LANE_HI];
    assign msb_pair_o = lane_msb;
endmodule

// File: rtl/twin_phase_nco_chk.sv
// Checker: temporal properties of the two-lane accumulator, bound to the top.
// Assumes reset is held low from time zero for at least one edge.
module twin_phase_nco_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_i,
    input logic [W-1:0] step_i,
    input logic [W-1:0] acc_a_o,
    input logic [W-1:0] acc_b_o
);
    logic         armed;
    logic [W-1:0] n_seen;

    // Purpose: mark that at least one edge has passed.
    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    // Purpose: remember the last loaded step (0 after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_seen <= '0;
        end else if (load_i) begin
            n_seen <= step_i;
        end
    end

    // R1: one edge after reset both lanes are zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        armed && !rst_n |=> (acc_a_o == '0) && (acc_b_o == '0));

    // R2: a load sets lane A to 0 and lane B to the step on the same edge
    assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (acc_a_o == '0) && (acc_b_o == $past(step_i)));

    // R3: both lanes advance by the same amount on a non-load edge
    assert_equal_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !load_i |=> W'(acc_a_o - $past(acc_a_o)) == W'(acc_b_o - $past(acc_b_o)));

    // R4: lane offset equals the loaded step
    assert_lane_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> W'(acc_b_o - acc_a_o) == n_seen);

    // R5: offset holds when step_i moves without a load
    assert_step_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !load_i |=> W'(acc_b_o - acc_a_o) == $past(W'(acc_b_o - acc_a_o)));
endmodule

bind twin_phase_nco twin_phase_nco_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .step_i  (step_i),
    .acc_a_o (acc_a_o),
    .acc_b_o (acc_b_o)
);

// File: tb/twin_phase_nco_test.sv
module twin_phase_nco_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] step_i = '0;
    logic        load_i = 1'b0;
    logic [15:0] acc_a_o, acc_b_o;
    logic [1:0]  msb_pair_o;
    logic        wave_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    twin_phase_nco uut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .load_i(load_i),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .msb_pair_o(msb_pair_o), .wave_o(wave_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // advance to 2 ns after the next rising edge
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // check j edges after a load of step n
    task automatic check_cycle(input logic [15:0] n, input int j);
        logic [15:0] ea, eb;
        ea = 16'(n * (2 * j));
        eb = 16'(n * (2 * j + 1));
        check("R3 lane A", acc_a_o, ea);
        check("R3 lane B", acc_b_o, eb);
        check("R4 offset", 16'(acc_b_o - acc_a_o), n);
        check("R6 msb pair", msb_pair_o, {eb[15], ea[15]});
        check("R8 interleave B", wave_o, eb[15]);
        @(negedge clk);
        #2;
        check("R7 low phase A", wave_o, ea[15]);
    endtask

    task automatic do_load(input logic [15:0] n);
        step_i = n;
        load_i = 1'b1;
        tick();
        load_i = 1'b0;
        check("R2 load A", acc_a_o, 16'h0000);
        check("R2 load B", acc_b_o, n);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        step_i = 16'h1234;
        tick(); tick();
        check("R1 reset A", acc_a_o, 0);
        check("R1 reset B", acc_b_o, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        check("R1 idle A", acc_a_o, 0);
        check("R1 idle B", acc_b_o, 0);
        check("R1 idle wave", wave_o, 0);
    endtask

    task automatic test_run(input logic [15:0] n, input int cycles);
        do_load(n);
        for (int j = 1; j <= cycles; j++) begin
            tick();
            check_cycle(n, j);
        end
    endtask

    task automatic test_ignore_step();
        do_load(16'h0300);
        for (int j = 1; j <= 6; j++) begin
            step_i = 16'(16'h5A5A + j);
            tick();
            check_cycle(16'h0300, j);
        end
        check("R5 step ignored", 16'(acc_b_o - acc_a_o), 16'h0300);
    endtask

    task automatic test_reload();
        do_load(16'h0777);
        for (int j = 1; j <= 4; j++) begin tick(); check_cycle(16'h0777, j); end
        test_run(16'h2001, 5);
        check("R9 reload offset", 16'(acc_b_o - acc_a_o), 16'h2001);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #3;
        test_reset();
        test_run(16'h0001, 8);
        test_run(16'h1234, 20);
        test_run(16'h8001, 12);   // R3: bit 15 of step dropped from stride
        test_run(16'hFFFF, 12);
        test_run(16'h4000, 10);
        test_ignore_step();
        test_reload();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule